// File: doc/BRIEF.md
# Three-Level Pulse Step Counter

This block turns excursions of one three-level control line into single steps of a 7-bit setting that drives a current-sink DAC. The line arrives as two comparator flags, one raised when the line sits above its mid level and one raised when it sits below. A pulse toward the low side raises the code by one and a pulse toward the high side lowers it by one. A pulse is only counted once it has held its level long enough, and once the line has returned to mid. Short glitches and pulses of middling width leave the code alone.

All width and spacing measurements run on a microsecond tick input, not on the clock. The code saturates at both ends. The first qualified pulse after reset is thrown away, because the comparators may start in an unknown state. A count-enable input gates every change. A parallel load port presets the code from a stored value at start-up. A one-cycle strobe marks each cycle in which the code moves.

Top module: `tri_level_step_counter`

## Requirements
- R1: With enable high, a low excursion (only the below-mid flag set) that qualifies raises `setting_o` by exactly one.
- R2: With enable high, a high excursion (only the above-mid flag set) that qualifies lowers `setting_o` by exactly one.
- R3: The code saturates. A raise at 127 leaves it at 127, a lowering at 0 leaves it at 0, and it never wraps.
- R4: An excursion qualifies only if it holds its level for at least MIN_WIDTH ticks (200 by default). Anything shorter changes nothing, including glitches below 20 ticks and widths from 20 to 199 ticks.
- R5: After a pulse ends, the line must stay at mid for GAP_TICKS ticks (10 by default) before a new excursion can count. An excursion that starts earlier is ignored in full.
- R6: The first qualified pulse after reset changes nothing. Later qualified pulses count.
- R7: With enable low at the moment a pulse completes, the code does not change.
- R8: A cycle with `load_i` high sets `setting_o` to `load_value_i` on the next edge. Load takes priority over a step in the same cycle.
- R9: `step_o` is high for exactly one cycle, in the same cycle in which `setting_o` changes through a step. It stays low otherwise.
- R10: If both flags are set at once, the excursion in progress is abandoned and does not count, whatever the line does afterwards.
- R11: A step is taken only when the line returns to mid. Holding a level far past MIN_WIDTH gives exactly one step and never repeats.
- R12: During and right after reset, `setting_o` equals RST_CODE (0 by default) and `step_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| above_mid_i | input | 1 | Comparator flag: line above mid (asynchronous) |
| below_mid_i | input | 1 | Comparator flag: line below mid (asynchronous) |
| count_en_i | input | 1 | Count enable, synchronous to clk |
| tick_us_i | input | 1 | One-cycle timebase tick, one per microsecond |
| load_i | input | 1 | Preset strobe |
| load_value_i | input | 7 | Stored code to preset |
| setting_o | output | 7 | Registered DAC setting |
| step_o | output | 1 | One-cycle strobe when a step moves the code |

## Verification
The assertions assume that `count_en_i`, `load_i` and `load_value_i` are synchronous to the clock. They also assume that the flags only need a short settling time, which the synchronizer provides. The stimulus changes every input on the falling clock edge and holds each flag level for whole multiples of the tick period. Its widths keep at least five ticks away from the MIN_WIDTH threshold, so the one-tick uncertainty of the sampling never decides whether a pulse is accepted. Every normal pulse is followed by a mid interval well beyond GAP_TICKS. Only the directed spacing test breaks that rule, on purpose.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {
    LVL_MID  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_BAD  = 2'd3
  } lvl_t;

  typedef enum logic [1:0] {
    Q_GAP  = 2'd0,
    Q_ARM  = 2'd1,
    Q_EXC  = 2'd2,
    Q_WAIT = 2'd3
  } qst_t;

  function automatic lvl_t classify(input logic hi, input logic lo);
    case ({hi, lo})
      2'b00:   return LVL_MID;
      2'b01:   return LVL_LOW;
      2'b10:   return LVL_HIGH;
      default: return LVL_BAD;
    endcase
  endfunction
endpackage

// File: rtl/tlc_flag_sync.sv
module tlc_flag_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/tlc_qualifier.sv
module tlc_qualifier
  import tlc_pkg::*;
#(
  parameter int MIN_WIDTH = 200,
  parameter int GAP_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  lvl_t lvl_i,
  input  logic tick_i,
  input  logic en_i,
  output logic req_up_o,
  output logic req_dn_o
);
  localparam int WW = $clog2(MIN_WIDTH + 1);
  localparam int GW = $clog2(GAP_TICKS + 1);

  qst_t          st;
  logic [WW-1:0] wcnt;
  logic [GW-1:0] gcnt;
  logic          dir_up;
  logic          primed;
  logic          accept;
  lvl_t          own_lvl;

  always_comb begin
    own_lvl  = dir_up ? LVL_LOW : LVL_HIGH;
    accept   = (st == Q_EXC) && (lvl_i == LVL_MID) && (wcnt >= WW'(MIN_WIDTH));
    req_up_o = accept && primed && en_i && dir_up;
    req_dn_o = accept && primed && en_i && !dir_up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= Q_GAP;
      wcnt   <= '0;
      gcnt   <= '0;
      dir_up <= 1'b0;
      primed <= 1'b0;
    end else begin
      case (st)
        Q_GAP: begin
          if (lvl_i != LVL_MID) begin
            st <= Q_WAIT;
          end else if (tick_i) begin
            if (gcnt >= GW'(GAP_TICKS - 1)) begin
              st   <= Q_ARM;
              gcnt <= '0;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
        end
        Q_WAIT: begin
          if (lvl_i == LVL_MID) begin
            st   <= Q_GAP;
            gcnt <= '0;
          end
        end
        Q_ARM: begin
          wcnt <= '0;
          case (lvl_i)
            LVL_LOW:  begin st <= Q_EXC; dir_up <= 1'b1; end
            LVL_HIGH: begin st <= Q_EXC; dir_up <= 1'b0; end
            LVL_BAD:  st <= Q_WAIT;
            default:  st <= Q_ARM;
          endcase
        end
        default: begin
          if (lvl_i == LVL_MID) begin
            st   <= Q_GAP;
            gcnt <= '0;
            if (accept) primed <= 1'b1;
          end else if (lvl_i == own_lvl) begin
            if (tick_i && (wcnt < WW'(MIN_WIDTH))) wcnt <= wcnt + 1'b1;
          end else begin
            st   <= Q_WAIT;
            wcnt <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tlc_sat_counter.sv
module tlc_sat_counter #(
  parameter int W        = 7,
  parameter int RST_CODE = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] value_o,
  output logic         step_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      value_o <= W'(RST_CODE);
      step_o  <= 1'b0;
    end else begin
      step_o <= 1'b0;
      if (load_i) begin
        value_o <= load_val_i;
      end else if (inc_i && (value_o != TOP)) begin
        value_o <= value_o + 1'b1;
        step_o  <= 1'b1;
      end else if (dec_i && (value_o != '0)) begin
        value_o <= value_o - 1'b1;
        step_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tri_level_step_counter.sv
module tri_level_step_counter
  import tlc_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int MIN_WIDTH   = 200,
  parameter int GAP_TICKS   = 10,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CODE    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              above_mid_i,
  input  logic              below_mid_i,
  input  logic              count_en_i,
  input  logic              tick_us_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] load_value_i,
  output logic [CODE_W-1:0] setting_o,
  output logic              step_o
);
  logic [1:0] flags_s;
  lvl_t       lvl;
  logic       req_up, req_dn;

  tlc_flag_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({above_mid_i, below_mid_i}),
    .q_o (flags_s)
  );

  assign lvl = classify(flags_s[1], flags_s[0]);

  tlc_qualifier #(.MIN_WIDTH(MIN_WIDTH), .GAP_TICKS(GAP_TICKS)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .lvl_i    (lvl),
    .tick_i   (tick_us_i),
    .en_i     (count_en_i),
    .req_up_o (req_up),
    .req_dn_o (req_dn)
  );

  tlc_sat_counter #(.W(CODE_W), .RST_CODE(RST_CODE)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .load_val_i (load_value_i),
    .inc_i      (req_up),
    .dec_i      (req_dn),
    .value_o    (setting_o),
    .step_o     (step_o)
  );
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              count_en_i,
  input logic              load_i,
  input logic [CODE_W-1:0] load_value_i,
  input logic [CODE_W-1:0] setting_o,
  input logic              step_o
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  // R1 / R2: without a load the code moves by at most one LSB per cycle
  p_one_lsb_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) |-> (setting_o == $past(setting_o)) ||
                       (setting_o == $past(setting_o) + 1'b1) ||
                       (setting_o == $past(setting_o) - 1'b1));

  p_no_wrap_top_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_i) && $past(setting_o) == TOP) |-> setting_o != '0);

  p_no_wrap_bot_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_i) && $past(setting_o) == '0) |-> setting_o != TOP);

  p_enable_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(count_en_i) && !$past(load_i)) |-> $stable(setting_o));

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    $past(load_i) |-> setting_o == $past(load_value_i));

  p_strobe_change_r9: assert property (@(posedge clk) disable iff (rst)
    step_o |-> setting_o != $past(setting_o));

  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!step_o && !$past(load_i)) |-> $stable(setting_o));

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o);
endmodule

bind tri_level_step_counter tlc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .count_en_i   (count_en_i),
  .load_i       (load_i),
  .load_value_i (load_value_i),
  .setting_o    (setting_o),
  .step_o       (step_o)
);

// File: tb/sim_tri_level_step_counter.sv
module sim_tri_level_step_counter;
  localparam int TK = 4;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       above = 1'b0, below = 1'b0, en = 1'b1, tick = 1'b0, load = 1'b0;
  logic [6:0] load_val = '0;
  logic [6:0] setting;
  logic       step;

  int checks = 0, failures = 0, seen_steps = 0, exp_steps = 0;
  int exp_val = 0;
  bit primed = 0, done = 0;

  always #4 clk = ~clk;

  tri_level_step_counter u0 (
    .clk(clk), .rst(rst), .above_mid_i(above), .below_mid_i(below),
    .count_en_i(en), .tick_us_i(tick), .load_i(load), .load_value_i(load_val),
    .setting_o(setting), .step_o(step)
  );

  initial forever begin
    repeat (TK - 1) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  always @(negedge clk) if (!rst && step) seen_steps++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v, input bit up);
    if (up) return (v >= 127) ? 127 : v + 1;
    return (v <= 0) ? 0 : v - 1;
  endfunction

  task automatic mid(input int ticks);
    above = 1'b0; below = 1'b0;
    repeat (ticks * TK) @(negedge clk);
  endtask

  task automatic excursion(input bit up, input int ticks);
    above = !up; below = up;
    repeat (ticks * TK) @(negedge clk);
    above = 1'b0; below = 1'b0;
  endtask

  // pulse with model update, assumes line was at mid for a full gap before
  task automatic pulse(input bit up, input int ticks, input bit e);
    int nv;
    en = e;
    excursion(up, ticks);
    mid(15);
    if (ticks >= 205) begin
      if (primed && e) begin
        nv = sat(exp_val, up);
        if (nv != exp_val) exp_steps++;
        exp_val = nv;
      end
      primed = 1;
    end
    en = 1'b1;
  endtask

  task automatic do_load(input int v);
    load_val = 7'(v);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    exp_val = v;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    chk(setting == 7'd0 && step == 1'b0, "R12", setting, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(setting == 7'd0 && step == 1'b0, "R12", setting, 0);
    mid(15);

    do_load(64);
    chk(setting == 7'(exp_val), "R8", setting, exp_val);

    // R6: first qualified pulse is thrown away
    pulse(1, 210, 1);
    chk(setting == 7'd64, "R6", setting, 64);
    pulse(1, 210, 1);
    chk(setting == 7'd65, "R1", setting, 65);
    pulse(0, 220, 1);
    chk(setting == 7'd64, "R2", setting, 64);

    // R4: short and middling widths rejected
    pulse(1, 10, 1);
    chk(setting == 7'd64, "R4 glitch", setting, 64);
    pulse(0, 3, 1);
    chk(setting == 7'd64, "R4 glitch", setting, 64);
    pulse(1, 120, 1);
    chk(setting == 7'd64, "R4 mid width", setting, 64);
    pulse(0, 195, 1);
    chk(setting == 7'd64, "R4 near limit", setting, 64);

    // R7: enable low
    pulse(1, 210, 0);
    chk(setting == 7'd64, "R7", setting, 64);

    // R11: long hold gives one step, on return to mid
    en = 1'b1;
    below = 1'b1;
    repeat (400 * TK) @(negedge clk);
    chk(setting == 7'd64, "R11 held", setting, 64);
    below = 1'b0;
    mid(15);
    exp_val = 65; exp_steps++;
    chk(setting == 7'd65, "R11", setting, 65);

    // R10: both flags mid-excursion abandon it
    below = 1'b1;
    repeat (100 * TK) @(negedge clk);
    above = 1'b1;
    repeat (2 * TK) @(negedge clk);
    above = 1'b0;
    repeat (150 * TK) @(negedge clk);
    mid(15);
    chk(setting == 7'd65, "R10", setting, 65);

    // R5: excursion starting too soon after a pulse is ignored
    excursion(1, 210);
    mid(3);
    excursion(1, 210);
    mid(15);
    exp_val = 66; exp_steps++;
    chk(setting == 7'd66, "R5", setting, 66);
    pulse(1, 210, 1);
    chk(setting == 7'd67, "R5 recovered", setting, 67);

    // R3: saturation at both ends
    do_load(125);
    for (int i = 0; i < 4; i++) pulse(1, 206, 1);
    chk(setting == 7'd127, "R3 top", setting, 127);
    do_load(1);
    for (int i = 0; i < 3; i++) pulse(0, 206, 1);
    chk(setting == 7'd0, "R3 bottom", setting, 0);

    // R8: load takes priority, no strobe
    do_load(90);
    chk(setting == 7'd90, "R8", setting, 90);

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit up, e, lng;
      int w;
      up  = 1'($urandom_range(0, 1));
      e   = ($urandom_range(0, 3) != 0);
      lng = 1'($urandom_range(0, 1));
      w   = lng ? 205 + $urandom_range(0, 40) : 1 + $urandom_range(0, 190);
      pulse(up, w, e);
      chk(setting == 7'(exp_val), lng ? "R1/R2 random" : "R4 random", setting, exp_val);
    end

    chk(seen_steps == exp_steps, "R9 strobes", seen_steps, exp_steps);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule